// File: doc/BRIEF.md
# Serial Transmit Clock and Frame-Sync Front End

This block produces and selects the clocks that pace a serial audio transmitter, and drives the transmit data line and frame-sync line from them. A high-frequency clock either comes in on a pin or is made inside by dividing the system clock by a programmable ratio from 1 to 16. A bit clock is then taken either from a pin or from an internal generator that steps on one chosen edge of the high-frequency clock. The direction of each of the three clock and sync pins is set on its own, and so are the active bit-clock edge, the active high-frequency edge and the level that marks a frame start.

All logic runs on the system clock. Pin clocks and pin frame sync are sampled every system cycle and turned into edge strobes. Data leaves MSB first, one word per frame. In output frame-sync mode the block frames itself. In input mode it waits for a frame sync that it samples on the edge opposite the drive edge. A receive strobe marks the sample edge when the receiver shares the transmit bit clock. One control-register write port holds the whole configuration.

Top module: `txck_front`

## Requirements
- R1: The control field at bits [3:0] holds a divider code. The internal high-frequency clock repeats every code+1 system cycles, and for an even ratio it is high for half of that. With code 0, the pin output is the system clock itself.
- R2: A new divider code takes effect only at the end of the current divided period. Every high or low stretch of the output therefore belongs to the old ratio or the new one, never a shortened mix.
- R3: Bit 9 sets the high-frequency pin direction: its output enable equals the bit. When the bit is 0 the pin input is the high-frequency source; when it is 1 the divider is.
- R4: Bit 6 picks the high-frequency edge on which the internal bit-clock generator toggles: rising when 0, falling when 1. The bit-clock pin output shows the toggle one system cycle after the high-frequency pin edge is sampled.
- R5: Bit 7 sets the bit-clock source. When it is 1 the internal generator drives the bit-clock pin with the output enable high, and its period is two high-frequency periods. When it is 0 the enable is low and the pin input clocks the shift logic.
- R6: Bit 4 picks the drive edge: data and output frame sync change only on bit-clock rising edges when 0 and only on falling edges when 1, one system cycle after the edge is sampled. On the other edge the data line holds.
- R7: A frame carries WORD_W bits of the transmit word, MSB first. The word is captured at the frame's first drive edge, and the load strobe is high for the one system cycle after that edge.
- R8: With bit 8 set (frame sync output, enable high), frames follow back to back every WORD_W drive edges, and frame sync is active for exactly the first bit of each frame.
- R9: Bit 5 sets frame-sync polarity: the active level is high when 0 and low when 1, on the pin output and on the pin input alike.
- R10: With bit 8 clear (frame sync input, enable low), the pin is sampled on the edge opposite the drive edge. An active level seen there starts a new frame at the next drive edge; an active level present only across a drive edge has no effect.
- R11: With bit 10 set (shared bit clock), the receive strobe is high for one system cycle after each sample edge. With it clear, the strobe stays low.
- R12: After reset all output enables are low, the data line is low, frame sync shows its inactive level, and the load and receive strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 11 | Control register write value |
| tx_word | input | WORD_W | Word to send in the next frame |
| word_ack | output | 1 | One-cycle pulse when tx_word is captured |
| sd_o | output | 1 | Serial transmit data |
| hck_i | input | 1 | High-frequency clock pin input |
| hck_o | output | 1 | High-frequency clock pin output |
| hck_oe | output | 1 | High-frequency clock pin output enable |
| bck_i | input | 1 | Bit clock pin input |
| bck_o | output | 1 | Bit clock pin output |
| bck_oe | output | 1 | Bit clock pin output enable |
| fs_i | input | 1 | Frame sync pin input |
| fs_o | output | 1 | Frame sync pin output |
| fs_oe | output | 1 | Frame sync pin output enable |
| rx_stb | output | 1 | Receive sample strobe in shared-clock mode |

## Verification
The bench builds the block with the default WORD_W of 8 and the 4-bit divider field. That reaches every divider code, including the pass-through code and the top ratio of 16. An 8-bit frame lets a whole frame and the start of the next fit in a short directed test. The bench drives the bit clock and high-frequency clock pins by hand, one edge at a time, so the effect of each polarity bit and of each edge can be checked on the cycle it is due.

// File: rtl/txck_pkg.sv
package txck_pkg;

  localparam int DIV_W = 4;

  typedef struct packed {
    logic             sync_on;
    logic             hck_dir;
    logic             fs_dir;
    logic             bck_dir;
    logic             hck_pol;
    logic             fs_pol;
    logic             bck_pol;
    logic [DIV_W-1:0] div_code;
  } txck_cfg_t;

  localparam int CFG_W = $bits(txck_cfg_t);

endpackage

// File: rtl/txck_hf_div.sv
module txck_hf_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             lvl,
  output logic             rise,
  output logic             fall,
  output logic             bypass
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] act_q, act_d;
  logic             lvl_q, lvl_d;
  logic [DIV_W:0]   ratio;
  logic [DIV_W-1:0] half_m1;
  logic             term;

  always_comb begin
    ratio   = {1'b0, act_q} + 1'b1;
    half_m1 = ratio[DIV_W:1] - 1'b1;
    bypass  = (act_q == '0);
    term    = (cnt_q == act_q);
    rise    = term;
    fall    = bypass | (cnt_q == half_m1);
    cnt_d   = term ? '0 : cnt_q + 1'b1;
    // the new code is adopted only at terminal count
    act_d   = term ? div_cfg : act_q;
    lvl_d   = lvl_q;
    if (term)      lvl_d = 1'b1;
    else if (fall) lvl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl = lvl_q;

endmodule

// File: rtl/txck_edge.sv
module txck_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin;
  end

  assign rise = pin & ~prev_q;
  assign fall = ~pin & prev_q;

endmodule

// File: rtl/txck_shift.sv
module txck_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive,
  input  logic              sample,
  input  logic              fs_out_mode,
  input  logic              fs_in_act,
  input  logic [WORD_W-1:0] word,
  output logic              sd,
  output logic              fs_act,
  output logic              ack
);

  localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              fs_q, fs_d;
  logic              pend_q, pend_d;
  logic              ack_q, ack_d;
  logic              start;

  always_comb begin
    start  = fs_out_mode ? (cnt_q == LAST) : pend_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    fs_d   = fs_q;
    ack_d  = 1'b0;
    pend_d = pend_q;
    if (drive) begin
      pend_d = 1'b0;
      if (start) begin
        sh_d  = word;
        cnt_d = '0;
        fs_d  = 1'b1;
        ack_d = 1'b1;
      end else begin
        sh_d  = {sh_q[WORD_W-2:0], 1'b0};
        cnt_d = (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
        fs_d  = 1'b0;
      end
    end else if (sample && fs_in_act && !fs_out_mode) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= LAST;
      fs_q   <= 1'b0;
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      fs_q   <= fs_d;
      pend_q <= pend_d;
      ack_q  <= ack_d;
    end
  end

  assign sd     = sh_q[WORD_W-1];
  assign fs_act = fs_q;
  assign ack    = ack_q;

endmodule

// File: rtl/txck_front.sv
module txck_front
  import txck_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CFG_W-1:0]  ctl_wdata,
  input  logic [WORD_W-1:0] tx_word,
  output logic              word_ack,
  output logic              sd_o,
  input  logic              hck_i,
  output logic              hck_o,
  output logic              hck_oe,
  input  logic              bck_i,
  output logic              bck_o,
  output logic              bck_oe,
  input  logic              fs_i,
  output logic              fs_o,
  output logic              fs_oe,
  output logic              rx_stb
);

  // reset: asserted at once, released through two flops
  logic rs1_q, rs2_q, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int = rs2_q;

  txck_cfg_t cfg_q, cfg_d;
  always_comb cfg_d = ctl_we ? txck_cfg_t'(ctl_wdata) : cfg_q;
  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) cfg_q <= '0;
    else          cfg_q <= cfg_d;
  end

  logic div_lvl, div_rise, div_fall, div_byp;
  txck_hf_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_int), .div_cfg(cfg_q.div_code),
    .lvl(div_lvl), .rise(div_rise), .fall(div_fall), .bypass(div_byp)
  );

  logic xh_rise, xh_fall, xb_rise, xb_fall;
  txck_edge u_hck_edge (
    .clk(clk), .rst_n(rst_int), .pin(hck_i), .rise(xh_rise), .fall(xh_fall)
  );
  txck_edge u_bck_edge (
    .clk(clk), .rst_n(rst_int), .pin(bck_i), .rise(xb_rise), .fall(xb_fall)
  );

  logic hf_rise, hf_fall, hf_step;
  logic bck_q, bck_d;
  logic b_rise, b_fall, tx_drive, tx_sample;
  logic rx_q, rx_d;

  always_comb begin
    hf_rise   = cfg_q.hck_dir ? div_rise : xh_rise;
    hf_fall   = cfg_q.hck_dir ? div_fall : xh_fall;
    hf_step   = cfg_q.hck_pol ? hf_fall : hf_rise;
    bck_d     = hf_step ? ~bck_q : bck_q;
    b_rise    = cfg_q.bck_dir ? (hf_step & ~bck_q) : xb_rise;
    b_fall    = cfg_q.bck_dir ? (hf_step &  bck_q) : xb_fall;
    tx_drive  = cfg_q.bck_pol ? b_fall : b_rise;
    tx_sample = cfg_q.bck_pol ? b_rise : b_fall;
    rx_d      = cfg_q.sync_on & tx_sample;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      bck_q <= 1'b0;
      rx_q  <= 1'b0;
    end else begin
      bck_q <= bck_d;
      rx_q  <= rx_d;
    end
  end

  logic fs_act;
  txck_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_int), .drive(tx_drive), .sample(tx_sample),
    .fs_out_mode(cfg_q.fs_dir), .fs_in_act(fs_i ^ cfg_q.fs_pol),
    .word(tx_word), .sd(sd_o), .fs_act(fs_act), .ack(word_ack)
  );

  assign hck_o  = div_byp ? clk : div_lvl;
  assign hck_oe = cfg_q.hck_dir;
  assign bck_o  = bck_q;
  assign bck_oe = cfg_q.bck_dir;
  assign fs_o   = fs_act ^ cfg_q.fs_pol;
  assign fs_oe  = cfg_q.fs_dir;
  assign rx_stb = rx_q;

endmodule

// File: rtl/txck_front_chk.sv
module txck_front_chk #(
  parameter int DIV_W = 4,
  parameter int CFG_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [CFG_W-1:0] ctl_wdata,
  input logic             hck_oe,
  input logic             bck_oe,
  input logic             sd_o,
  input logic             tx_drive,
  input logic             word_ack,
  input logic             fs_o,
  input logic             fs_pol,
  input logic             sync_on,
  input logic             rx_stb,
  input logic             hf_lvl,
  input logic             hf_byp
);

  localparam int HALF_MAX = 2 ** (DIV_W - 1);
  localparam int HW = DIV_W + 1;

  logic [HW-1:0] hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hi_q <= '0;
    else if (hf_lvl && !hf_byp)          hi_q <= (hi_q == HW'(HALF_MAX + 1)) ? hi_q : hi_q + 1'b1;
    else                                 hi_q <= '0;
  end

  // R1: no divided high stretch longer than half the top ratio
  p_hf_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q <= HW'(HALF_MAX));

  p_hck_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (hck_oe == $past(ctl_wdata[9])));

  p_bck_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (bck_oe == $past(ctl_wdata[7])));

  p_sd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_drive |=> $stable(sd_o));

  p_fs_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_ack |-> (fs_o == !fs_pol));

  p_rx_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sync_on) |-> !rx_stb);

endmodule

bind txck_front txck_front_chk #(.DIV_W(txck_pkg::DIV_W), .CFG_W(txck_pkg::CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_int), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .hck_oe(hck_oe), .bck_oe(bck_oe), .sd_o(sd_o), .tx_drive(tx_drive),
  .word_ack(word_ack), .fs_o(fs_o), .fs_pol(cfg_q.fs_pol), .sync_on(cfg_q.sync_on),
  .rx_stb(rx_stb), .hf_lvl(div_lvl), .hf_byp(div_byp)
);

// File: tb/txck_front_tb.sv
module txck_front_tb;

  localparam int CLK_P  = 10;
  localparam int WORD_W = 8;
  localparam int CFG_W  = 11;

  localparam logic [CFG_W-1:0] B_CKP  = 11'h010;
  localparam logic [CFG_W-1:0] B_FSP  = 11'h020;
  localparam logic [CFG_W-1:0] B_HCKP = 11'h040;
  localparam logic [CFG_W-1:0] B_BCKD = 11'h080;
  localparam logic [CFG_W-1:0] B_FSD  = 11'h100;
  localparam logic [CFG_W-1:0] B_HCKD = 11'h200;
  localparam logic [CFG_W-1:0] B_SYNC = 11'h400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [CFG_W-1:0] ctl_wdata = '0;
  logic [WORD_W-1:0] tx_word = '0;
  logic hck_i = 1'b0, bck_i = 1'b0, fs_i = 1'b0;
  logic word_ack, sd_o, hck_o, hck_oe, bck_o, bck_oe, fs_o, fs_oe, rx_stb;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  txck_front #(.WORD_W(WORD_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .tx_word(tx_word), .word_ack(word_ack), .sd_o(sd_o),
    .hck_i(hck_i), .hck_o(hck_o), .hck_oe(hck_oe),
    .bck_i(bck_i), .bck_o(bck_o), .bck_oe(bck_oe),
    .fs_i(fs_i), .fs_o(fs_o), .fs_oe(fs_oe), .rx_stb(rx_stb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ctl_we = 1'b0; bck_i = 1'b0; hck_i = 1'b0; fs_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [CFG_W-1:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // set bit-clock pin at a falling system edge, return one cycle later
  task automatic bck_set(input logic v);
    bck_i = v;
    @(negedge clk);
  endtask

  function automatic logic pick(input int sel);
    return (sel == 0) ? hck_o : bck_o;
  endfunction

  task automatic measure(input int sel, output int per, output int hi);
    int guard;
    bit low_seen;
    guard = 0;
    while (pick(sel) !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
    while (pick(sel) !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
    per = 1; hi = 1; low_seen = 1'b0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (pick(sel) === 1'b0) low_seen = 1'b1;
      else if (low_seen) break;
      else hi++;
      per++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R12 hck_oe", hck_oe, 0);
    check("R12 bck_oe", bck_oe, 0);
    check("R12 fs_oe", fs_oe, 0);
    check("R12 sd_o", sd_o, 0);
    check("R12 fs_o", fs_o, 0);
    check("R12 word_ack", word_ack, 0);
    check("R12 rx_stb", rx_stb, 0);
  endtask

  task automatic t_dirs();
    write_cfg(B_HCKD | B_BCKD | B_FSD);
    check("R3 hck_oe", hck_oe, 1);
    check("R5 bck_oe", bck_oe, 1);
    check("R8 fs_oe", fs_oe, 1);
    write_cfg('0);
    check("R3 hck_oe off", hck_oe, 0);
  endtask

  task automatic t_div();
    int per, hi;
    do_reset();
    write_cfg(B_HCKD | 11'd1);
    repeat (20) @(negedge clk);
    measure(0, per, hi);
    check("R1 ratio2 period", per, 2);
    check("R1 ratio2 high", hi, 1);
    write_cfg(B_HCKD | 11'd3);
    repeat (20) @(negedge clk);
    measure(0, per, hi);
    check("R1 ratio4 period", per, 4);
    check("R1 ratio4 high", hi, 2);
    write_cfg(B_HCKD | 11'd15);
    repeat (40) @(negedge clk);
    measure(0, per, hi);
    check("R1 ratio16 period", per, 16);
    check("R1 ratio16 high", hi, 8);
    write_cfg(B_HCKD | 11'd0);
    repeat (40) @(negedge clk);
    check("R1 bypass low phase", hck_o, 0);
    @(posedge clk); #1;
    check("R1 bypass high phase", hck_o, 1);
    @(negedge clk);
  endtask

  task automatic t_glitch();
    int per, hi, run, bad, nrun;
    logic prev;
    do_reset();
    write_cfg(B_HCKD | 11'd3);
    repeat (17) @(negedge clk);
    write_cfg(B_HCKD | 11'd15);
    prev = hck_o; run = 0; bad = 0; nrun = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (hck_o === prev) run++;
      else begin
        if (nrun > 0 && run + 1 != 2 && run + 1 != 8) bad++;
        nrun++;
        run = 0;
        prev = hck_o;
      end
    end
    check("R2 runt stretches", bad, 0);
    measure(0, per, hi);
    check("R2 new period", per, 16);
  endtask

  task automatic t_hckp();
    logic b0;
    do_reset();
    write_cfg(B_BCKD);
    b0 = bck_o;
    hck_i = 1'b1; @(negedge clk);
    check("R4 rise steps (pol0)", bck_o, !b0);
    b0 = bck_o;
    hck_i = 1'b0; @(negedge clk);
    check("R4 fall ignored (pol0)", bck_o, b0);
    write_cfg(B_BCKD | B_HCKP);
    b0 = bck_o;
    hck_i = 1'b1; @(negedge clk);
    check("R4 rise ignored (pol1)", bck_o, b0);
    hck_i = 1'b0; @(negedge clk);
    check("R4 fall steps (pol1)", bck_o, !b0);
  endtask

  task automatic t_int_bck();
    int per, hi;
    do_reset();
    write_cfg(B_HCKD | B_BCKD | 11'd1);
    repeat (10) @(negedge clk);
    measure(1, per, hi);
    check("R5 bck period ratio2", per, 4);
    write_cfg(B_HCKD | B_BCKD | 11'd3);
    repeat (20) @(negedge clk);
    measure(1, per, hi);
    check("R5 bck period ratio4", per, 8);
  endtask

  task automatic t_frame_out();
    logic [WORD_W-1:0] w;
    logic s;
    do_reset();
    write_cfg(B_FSD);
    w = 8'hA5; tx_word = w;
    for (int i = 0; i < WORD_W; i++) begin
      bck_set(1'b1);
      check("R7 data bit", sd_o, w[WORD_W-1-i]);
      check("R8 fs on first bit", fs_o, (i == 0));
      if (i == 0) begin
        check("R7 load strobe", word_ack, 1);
        tx_word = 8'h3C;
      end
      s = sd_o;
      bck_set(1'b0);
      check("R6 hold on fall", sd_o, s);
      if (i == 0) check("R7 strobe one cycle", word_ack, 0);
    end
    bck_set(1'b1);
    check("R8 next frame fs", fs_o, 1);
    check("R7 next word msb", sd_o, 0);
    check("R7 next load strobe", word_ack, 1);
    bck_set(1'b0);
    bck_set(1'b1);
    check("R7 next word bit6", sd_o, 0);
    bck_set(1'b0);
    bck_set(1'b1);
    check("R7 next word bit5", sd_o, 1);
  endtask

  task automatic t_frame_ckp1();
    do_reset();
    write_cfg(B_FSD | B_CKP);
    tx_word = 8'hC3;
    bck_set(1'b1);
    check("R6 rise no drive (pol1)", word_ack, 0);
    bck_set(1'b0);
    check("R6 fall drives (pol1)", sd_o, 1);
    check("R8 fs on fall (pol1)", fs_o, 1);
    bck_set(1'b1);
    check("R6 hold on rise", sd_o, 1);
    bck_set(1'b0);
    check("R6 bit6", sd_o, 1);
    check("R8 fs second bit", fs_o, 0);
    bck_set(1'b1);
    bck_set(1'b0);
    check("R6 bit5", sd_o, 0);
  endtask

  task automatic t_fsp();
    do_reset();
    write_cfg(B_FSD | B_FSP);
    tx_word = 8'hFF;
    check("R9 idle level", fs_o, 1);
    bck_set(1'b1);
    check("R9 active low", fs_o, 0);
    bck_set(1'b0);
    bck_set(1'b1);
    check("R9 inactive high", fs_o, 1);
  endtask

  task automatic t_fs_in();
    do_reset();
    write_cfg('0);
    tx_word = 8'h81;
    check("R10 fs_oe low", fs_oe, 0);
    bck_set(1'b1);
    check("R10 no frame without sync", word_ack, 0);
    fs_i = 1'b1;
    bck_set(1'b0);
    fs_i = 1'b0;
    bck_set(1'b1);
    check("R10 sync starts frame", word_ack, 1);
    check("R10 msb out", sd_o, 1);
    fs_i = 1'b1;
    bck_set(1'b0);
    fs_i = 1'b1;
    bck_set(1'b1);
    check("R10 restart by sampled sync", word_ack, 1);
    fs_i = 1'b0;
    bck_set(1'b0);
    fs_i = 1'b1;
    bck_set(1'b1);
    fs_i = 1'b0;
    check("R10 drive-edge sync ignored", word_ack, 0);
    check("R10 shifting continues", sd_o, 0);
    write_cfg(B_FSP);
    fs_i = 1'b0;
    bck_set(1'b0);
    fs_i = 1'b1;
    bck_set(1'b1);
    check("R9 low input sync starts frame", word_ack, 1);
  endtask

  task automatic t_sync();
    do_reset();
    write_cfg(B_FSD | B_SYNC);
    bck_set(1'b1);
    check("R11 none on drive edge", rx_stb, 0);
    bck_set(1'b0);
    check("R11 strobe on sample edge", rx_stb, 1);
    @(negedge clk);
    check("R11 strobe one cycle", rx_stb, 0);
    write_cfg(B_FSD);
    bck_set(1'b1);
    bck_set(1'b0);
    check("R11 quiet when not shared", rx_stb, 0);
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual 1 expected 0");
    finish_sim();
  end

  initial begin
    t_reset();
    t_dirs();
    t_div();
    t_glitch();
    t_hckp();
    t_int_bck();
    t_frame_out();
    t_frame_ckp1();
    t_fsp();
    t_fs_in();
    t_sync();
    finish_sim();
  end

endmodule